// File: doc/BRIEF.md
# Synthesizer Divider Programming Interface

This block holds the programming state of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 3-bit test-select code. Two loading paths write it. The parallel path takes the divide values from pins whose capture is qualified by an active-low strobe. The serial path takes a data line, a shift clock and a load strobe, and feeds a 14-bit shift register. Both paths share one active register set, and that set drives the divider hardware.

Every strobe and the serial data arrive asynchronously. Each passes through a two-flop synchronizer into the system clock domain, and its edges are found there. The block also reports whether the feedback value lies inside the range where the loop can lock. It exposes the oldest shift-register bit, and a test output that carries this bit when the test-select code is zero. The loop filter, oscillator and actual division are outside this block.

Top module: `divprog_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are as follows: feedback value 100, output code 00, test code 000, an empty shift register (serial out 0), in-range flag 1 and test output 0.
- R2: While the synchronized parallel strobe is low, the feedback and output-code registers follow the pins. The test code is never written through the pins.
- R3: On the rising edge of the synchronized parallel strobe, the pin values are captured. Later pin changes have no effect until the strobe falls again or a serial load occurs.
- R4: While the parallel strobe is high, each rising shift-clock edge shifts the data bit into bit 0 of a 14-bit register. A frame is sent most significant bit first. Bits 13:11 carry the test code, bits 10:9 the output code and bits 8:0 the feedback value, so the first bit sent is test bit 2 and the last is feedback bit 0.
- R5: A rising edge of the serial load strobe copies the whole shift register into the test, output-code and feedback registers. A falling edge leaves them holding those values, and shifting while the strobe is low does not change them.
- R6: While the serial load strobe is held high and the parallel strobe is high, each shift-clock rising edge shifts the register and loads the shifted frame into the registers in the same step.
- R7: While the parallel strobe is low, shift-clock edges change neither the shift register nor the test code.
- R8: The in-range flag is 1 exactly when the feedback value lies between 100 and 350 inclusive.
- R9: The serial out is bit 13 of the shift register, which is the oldest bit held. The test output equals the serial out when the test code is 000, and is 0 for any other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| par_ld_n | input | 1 | Parallel strobe, asynchronous, active low |
| par_m | input | 9 | Parallel feedback value pins |
| par_n | input | 2 | Parallel output-code pins |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load strobe, asynchronous |
| m_val | output | 9 | Active feedback divide value |
| n_code | output | 2 | Active output divide code |
| t_code | output | 3 | Active test-select code |
| m_ok | output | 1 | Feedback value inside the lockable range |
| sr_out | output | 1 | Oldest shift-register bit |
| test_out | output | 1 | Test output, carries sr_out when test code is 000 |

## Verification
On every cycle the assertions check the following rules. Registers hold when no load event occurred. The whole frame appears in the registers after a transfer or a pass-through step. Shifting moves bit 12 into the serial out. The test code changes only while the parallel strobe is high. The range flag and the test-output selection are also checked every cycle. Only the bench scenarios can show three things. The bit order of a full frame must land in the right fields. Pin values must stay frozen after a capture. Shift-clock activity while the parallel strobe is low must leave no trace in a later transfer.

// File: rtl/divprog_pkg.sv
package divprog_pkg;
  parameter int M_W   = 9;
  parameter int N_W   = 2;
  parameter int T_W   = 3;
  parameter int M_MIN = 100;
  parameter int M_MAX = 350;
  parameter int M_RST = 100;
  parameter int SYNC_STAGES = 2;

  localparam int FRAME_W = T_W + N_W + M_W;

  // Frame layout: test code in the top bits, feedback value at the bottom.
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } frame_t;
endpackage

// File: rtl/divprog_sync.sv
module divprog_sync #(
  parameter int           W      = 3,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] dly_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] dly_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stg_d;
      if (g == 0) begin : g_first
        assign stg_d = async_i;
      end else begin : g_next
        assign stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= RST;
    else        dly_q <= stg_q[STAGES-1];
  end

  assign lvl_o = stg_q[STAGES-1];
  assign dly_o = dly_q;
endmodule

// File: rtl/divprog_shreg.sv
module divprog_shreg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= sr_d;
  end

  assign q_o   = sr_q;
  assign nxt_o = sr_d;
endmodule

// File: rtl/divprog_range.sv
module divprog_range #(
  parameter int W   = 9,
  parameter int MIN = 100,
  parameter int MAX = 350
) (
  input  logic [W-1:0] val_i,
  output logic         ok_o
);
  localparam logic [W-1:0] LO = W'(MIN);
  localparam logic [W-1:0] HI = W'(MAX);

  always_comb begin
    ok_o = (val_i >= LO) && (val_i <= HI);
  end
endmodule

// File: rtl/divprog_ctrl.sv
module divprog_ctrl
  import divprog_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_ld_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] t_code,
  output logic           m_ok,
  output logic           sr_out,
  output logic           test_out
);
  localparam int NSTB     = 3;
  localparam int IX_SCLK  = 0;
  localparam int IX_PL    = 1;
  localparam int IX_SL    = 2;
  localparam logic [NSTB-1:0] STB_RST = 3'b010;

  logic [NSTB-1:0] stb_lvl, stb_dly;
  logic            pl_lvl, pl_rise, sl_hi, sl_rise, sclk_rise;
  logic [SYNC_STAGES-1:0] dat_q;
  logic            dat_s;
  logic [FRAME_W-1:0] sr_q, sr_nxt;
  frame_t          frm_cur, frm_nxt;
  logic            shift_en;

  logic [M_W-1:0] m_q, m_d;
  logic [N_W-1:0] n_q, n_d;
  logic [T_W-1:0] t_q, t_d;

  divprog_sync #(.W(NSTB), .STAGES(SYNC_STAGES), .RST(STB_RST)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({ser_ld, par_ld_n, ser_clk}),
    .lvl_o  (stb_lvl),
    .dly_o  (stb_dly)
  );

  // Data line goes through the same depth so it lines up with the clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dat_q <= '0;
    else        dat_q <= {dat_q[SYNC_STAGES-2:0], ser_dat};
  end
  assign dat_s = dat_q[SYNC_STAGES-1];

  assign pl_lvl    = stb_lvl[IX_PL];
  assign pl_rise   = stb_lvl[IX_PL] & ~stb_dly[IX_PL];
  assign sl_hi     = stb_lvl[IX_SL];
  assign sl_rise   = stb_lvl[IX_SL] & ~stb_dly[IX_SL];
  assign sclk_rise = stb_lvl[IX_SCLK] & ~stb_dly[IX_SCLK];

  assign shift_en  = pl_lvl & sclk_rise;

  divprog_shreg #(.W(FRAME_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .din     (dat_s),
    .q_o     (sr_q),
    .nxt_o   (sr_nxt)
  );

  assign frm_cur = frame_t'(sr_q);
  assign frm_nxt = frame_t'(sr_nxt);

  // Next state of the active registers
  always_comb begin
    m_d = m_q;
    n_d = n_q;
    t_d = t_q;
    if (!pl_lvl || pl_rise) begin
      m_d = par_m;
      n_d = par_n;
    end else if (sl_hi && sclk_rise) begin
      m_d = frm_nxt.m;
      n_d = frm_nxt.n;
      t_d = frm_nxt.t;
    end else if (sl_rise) begin
      m_d = frm_cur.m;
      n_d = frm_cur.n;
      t_d = frm_cur.t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= M_W'(M_RST);
      n_q <= '0;
      t_q <= '0;
    end else begin
      m_q <= m_d;
      n_q <= n_d;
      t_q <= t_d;
    end
  end

  divprog_range #(.W(M_W), .MIN(M_MIN), .MAX(M_MAX)) u_range (
    .val_i(m_q),
    .ok_o (m_ok)
  );

  assign m_val    = m_q;
  assign n_code   = n_q;
  assign t_code   = t_q;
  assign sr_out   = sr_q[FRAME_W-1];
  assign test_out = (t_q == '0) ? sr_q[FRAME_W-1] : 1'b0;
endmodule

// File: rtl/divprog_chk.sv
module divprog_chk
  import divprog_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               pl_lvl,
  input logic               pl_rise,
  input logic               sl_hi,
  input logic               sl_rise,
  input logic               sclk_rise,
  input logic [FRAME_W-1:0] sr_q,
  input logic [M_W-1:0]     par_m,
  input logic [N_W-1:0]     par_n,
  input logic [M_W-1:0]     m_val,
  input logic [N_W-1:0]     n_code,
  input logic [T_W-1:0]     t_code,
  input logic               m_ok,
  input logic               sr_out,
  input logic               test_out
);
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pl_lvl) |-> (m_val == $past(par_m)) && (n_code == $past(par_n))); // R2

  AST_T_PAR_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(t_code) |-> $past(pl_lvl)); // R2

  AST_HOLD_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pl_lvl) && !$past(pl_rise) && !$past(sl_rise) && !$past(sl_hi && sclk_rise))
      |-> ($stable(m_val) && $stable(n_code) && $stable(t_code))); // R3

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pl_lvl && sclk_rise) |-> (sr_out == $past(sr_q[FRAME_W-2]))); // R4

  AST_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pl_lvl && !pl_rise && sl_rise) |-> ({t_code, n_code, m_val} == sr_q)); // R5

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pl_lvl && !pl_rise && sl_hi && sclk_rise) |-> ({t_code, n_code, m_val} == sr_q)); // R6

  AST_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pl_lvl && sclk_rise) |-> $stable(sr_q)); // R7

  AST_RANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_val < 9'd100) || (m_val > 9'd350)) |-> !m_ok); // R8

  AST_RANGE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_val >= 9'd100) && (m_val <= 9'd350)) |-> m_ok); // R8

  AST_TEST_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code != 3'b000) |-> !test_out); // R9

  AST_TEST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b000) |-> (test_out == sr_out)); // R9
endmodule

bind divprog_ctrl divprog_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pl_lvl   (pl_lvl),
  .pl_rise  (pl_rise),
  .sl_hi    (sl_hi),
  .sl_rise  (sl_rise),
  .sclk_rise(sclk_rise),
  .sr_q     (sr_q),
  .par_m    (par_m),
  .par_n    (par_n),
  .m_val    (m_val),
  .n_code   (n_code),
  .t_code   (t_code),
  .m_ok     (m_ok),
  .sr_out   (sr_out),
  .test_out (test_out)
);

// File: tb/test_divprog_ctrl.sv
`timescale 1ns/1ps
module test_divprog_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_ld_n;
  logic [8:0] par_m;
  logic [1:0] par_n;
  logic       ser_clk, ser_dat, ser_ld;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic [2:0] t_code;
  logic       m_ok, sr_out, test_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [13:0] exp_sr;

  always #4 clk = ~clk;

  divprog_ctrl i_divprog_ctrl (
    .clk(clk), .rst_n(rst_n), .par_ld_n(par_ld_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .m_val(m_val), .n_code(n_code), .t_code(t_code), .m_ok(m_ok),
    .sr_out(sr_out), .test_out(test_out)
  );

  // bit 14: expected range flag; bits 13:11 test, 10:9 out code, 8:0 feedback
  localparam logic [14:0] VEC [8] = '{
    {1'b1, 3'b101, 2'b10, 9'd100},
    {1'b0, 3'b000, 2'b01, 9'd99},
    {1'b1, 3'b011, 2'b11, 9'd350},
    {1'b0, 3'b110, 2'b00, 9'd351},
    {1'b0, 3'b100, 2'b00, 9'd0},
    {1'b0, 3'b111, 2'b11, 9'd511},
    {1'b1, 3'b010, 2'b01, 9'd200},
    {1'b1, 3'b001, 2'b10, 9'd101}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, input bit counted);
    ser_dat = b;
    step(4);
    ser_clk = 1'b1;
    step(4);
    ser_clk = 1'b0;
    step(4);
    if (counted) exp_sr = {exp_sr[12:0], b};
  endtask

  task automatic shift_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) shift_bit(f[i], 1'b1);
  endtask

  task automatic pulse_load();
    ser_ld = 1'b1;
    step(5);
    ser_ld = 1'b0;
    step(5);
  endtask

  initial begin
    rst_n = 1'b0; par_ld_n = 1'b1; par_m = '0; par_n = '0;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_ld = 1'b0;
    exp_sr = '0;
    step(3);
    // R1 during reset
    chk("R1", "m in reset", 32'(m_val), 32'd100);
    chk("R1", "n in reset", 32'(n_code), 32'd0);
    chk("R1", "t in reset", 32'(t_code), 32'd0);
    rst_n = 1'b1;
    step(5);
    chk("R1", "m after reset", 32'(m_val), 32'd100);
    chk("R1", "ok after reset", 32'(m_ok), 32'd1);
    chk("R1", "sr_out after reset", 32'(sr_out), 32'd0);
    chk("R1", "test_out after reset", 32'(test_out), 32'd0);

    // Table: serial frames, transfer on strobe rise (R4, R5, R8, R9)
    for (int v = 0; v < 8; v++) begin
      logic [8:0] m_before;
      m_before = m_val;
      shift_frame(VEC[v][13:0]);
      chk("R5", "m held while shifting", 32'(m_val), 32'(m_before));
      chk("R9", "sr_out oldest bit", 32'(sr_out), 32'(VEC[v][13]));
      pulse_load();
      chk("R4", "m field", 32'(m_val), 32'(VEC[v][8:0]));
      chk("R4", "n field", 32'(n_code), 32'(VEC[v][10:9]));
      chk("R4", "t field", 32'(t_code), 32'(VEC[v][13:11]));
      chk("R8", "range flag", 32'(m_ok), 32'(VEC[v][14]));
      chk("R9", "test_out", 32'(test_out),
          32'((VEC[v][13:11] == 3'b000) ? exp_sr[13] : 1'b0));
    end

    // R9: test code 000 routes the shift register to the test output
    shift_frame({3'b000, 2'b10, 9'd7});
    pulse_load();
    shift_bit(1'b0, 1'b1);
    shift_bit(1'b0, 1'b1);
    shift_bit(1'b0, 1'b1);
    chk("R9", "routed sr_out", 32'(sr_out), 32'd1);
    chk("R9", "test_out routed", 32'(test_out), 32'd1);
    chk("R5", "m held after shifts", 32'(m_val), 32'd7);

    // R2: parallel transparent
    par_m = 9'd123; par_n = 2'd2; par_ld_n = 1'b0;
    step(6);
    chk("R2", "m follows pins", 32'(m_val), 32'd123);
    chk("R2", "n follows pins", 32'(n_code), 32'd2);
    par_m = 9'd300; par_n = 2'd1;
    step(3);
    chk("R2", "m follows new pins", 32'(m_val), 32'd300);
    chk("R2", "t untouched by pins", 32'(t_code), 32'd0);

    // R3: capture on strobe rise, then pins ignored
    par_m = 9'd250; par_n = 2'd3;
    step(2);
    par_ld_n = 1'b1;
    step(6);
    par_m = 9'd50; par_n = 2'd0;
    step(6);
    chk("R3", "m frozen", 32'(m_val), 32'd250);
    chk("R3", "n frozen", 32'(n_code), 32'd3);
    chk("R8", "ok for 250", 32'(m_ok), 32'd1);

    // R7: shift clock ignored while parallel strobe low
    par_m = 9'd333; par_n = 2'd1; par_ld_n = 1'b0;
    step(6);
    shift_bit(1'b1, 1'b0);
    shift_bit(1'b1, 1'b0);
    chk("R7", "sr_out unchanged", 32'(sr_out), 32'(exp_sr[13]));
    par_ld_n = 1'b1;
    step(6);
    pulse_load();
    chk("R7", "t after transfer", 32'(t_code), 32'(exp_sr[13:11]));
    chk("R7", "m after transfer", 32'(m_val), 32'(exp_sr[8:0]));

    // R6: load strobe held high, each shift loads the registers
    ser_ld = 1'b1;
    step(6);
    for (int k = 0; k < 5; k++) begin
      logic b;
      b = k[0] ^ k[1];
      shift_bit(b, 1'b1);
      chk("R6", "m pass-through", 32'(m_val), 32'(exp_sr[8:0]));
      chk("R6", "t pass-through", 32'(t_code), 32'(exp_sr[13:11]));
    end
    ser_ld = 1'b0;
    step(6);
    chk("R5", "held after strobe fall", 32'(m_val), 32'(exp_sr[8:0]));

    // R1: reset again mid-run
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(4);
    chk("R1", "m after second reset", 32'(m_val), 32'd100);
    chk("R1", "sr cleared", 32'(sr_out), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule